// File: doc/BRIEF.md
# Multicycle Load/Store Integer Core

This block is a small non-pipelined integer core. Each instruction walks through a fixed chain of steps: fetch, decode, execute, memory and write-back. Each step takes one clock cycle when memory answers at once. A single ALU does every addition and comparison, with its operands chosen per step. Intermediate values are kept in holding registers: the instruction word, two operand latches, an ALU result latch and a memory data latch. The instruction kinds are register-register arithmetic and logic, word load, word store and branch-if-equal. Every instruction is 32 bits wide and its register fields sit at fixed positions.

Instruction and data traffic use two separate request/acknowledge ports. A request stays up with its address and data frozen until the memory raises the acknowledge. The returned word is taken on the clock edge where the acknowledge is seen. Branch-if-equal finishes in three steps, arithmetic and store in four, and load in five. The branch target is added up during decode, before the opcode has been examined.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `dmem_req` is low. Reset is released through a two-stage synchronizer, so the core acts on the third rising edge after `rst_n` rises. The first instruction accepted is fetched from `RESET_PC`.
- R2: A fetch loads the instruction word from the address in the PC and adds 4 to the PC. Instructions without a taken branch are fetched at consecutive word addresses.
- R3: With opcode 0x00 and IR[10:6] equal to zero, IR[5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2a signed set-less-than (result 1 or 0). The operands are the registers in IR[25:21] and IR[20:16]. The result is written to the register in IR[15:11], and the instruction takes 4 cycles.
- R4: Opcode 0x23 reads the data word at the register in IR[25:21] plus the sign-extended IR[15:0]. The word is written to the register in IR[20:16], and the instruction takes 5 cycles.
- R5: Opcode 0x2b writes the register in IR[20:16] to the data word at the register in IR[25:21] plus the sign-extended IR[15:0]. It takes 4 cycles.
- R6: Opcode 0x04 compares the registers in IR[25:21] and IR[20:16]. If they are equal, the next fetch is at the incremented PC plus the sign-extended IR[15:0] as a byte offset. Otherwise execution continues in sequence. The instruction takes 3 cycles either way.
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: These words are unrecognised: any other opcode, an unlisted function code, or a nonzero IR[10:6] with opcode 0x00. Such a word returns to fetch after 2 cycles and changes nothing but the PC step.
- R9: While a request waits for its acknowledge, the request, address, write enable and write data stay unchanged, and the core does not advance.
- R10: The instruction port and the data port never request in the same cycle. A data request appears only in the memory step of a load or store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | Instruction fetch request |
| imem_addr | output | 32 | Fetch byte address (the PC) |
| imem_ack | input | 1 | Fetch acknowledge; `imem_rdata` is valid in the same cycle |
| imem_rdata | input | 32 | Instruction word |
| dmem_req | output | 1 | Data access request |
| dmem_we | output | 1 | 1 for store, 0 for load |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_ack | input | 1 | Data acknowledge; `dmem_rdata` is valid in the same cycle |
| dmem_rdata | input | 32 | Load data |

## Verification
The bench builds the core with `RESET_PC` set to 0x40. Because this vector is not zero, the first-fetch check shows that the parameter is really used. The word width and register count stay at their defaults of 32. The bench memory model has adjustable wait states. With zero waits, the spacing between accepted fetches gives the exact cycle cost of each instruction kind. With two instruction waits and three data waits, the bench can see a request held still across several cycles.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2b;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2a;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} step_t;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_t;
  typedef enum logic [2:0] {K_ARITH, K_LOAD, K_STORE, K_BRANCH, K_BAD} ikind_t;
  typedef enum logic [1:0] {OPB_REG, OPB_FOUR, OPB_IMM} opb_sel_t;

  function automatic logic fn_known(logic [FN_W-1:0] fn);
    return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
           (fn == FN_OR)  || (fn == FN_SLT);
  endfunction

  function automatic ikind_t classify(logic [OP_W-1:0] op, logic [FN_W-1:0] fn,
                                      logic [4:0] shamt);
    case (op)
      OP_REG:   return (fn_known(fn) && shamt == '0) ? K_ARITH : K_BAD;
      OP_LOAD:  return K_LOAD;
      OP_STORE: return K_STORE;
      OP_BEQ:   return K_BRANCH;
      default:  return K_BAD;
    endcase
  endfunction

  function automatic alu_op_t fn_to_op(logic [FN_W-1:0] fn);
    case (fn)
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      FN_SLT:  return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data
);
  // Storage array carries no reset; entry 0 is never written.
  logic [W-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr != '0)) cells[wr_addr] <= wr_data;
  end

  assign ra_data = (ra_addr == '0) ? '0 : cells[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : cells[rb_addr];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         is_zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = opa - opb;
      ALU_AND: y = opa & opb;
      ALU_OR:  y = opa | opb;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: y = opa + opb;
    endcase
  end
  assign is_zero = (y == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  input  logic [4:0]      shamt,
  input  logic            imem_ack,
  input  logic            dmem_ack,
  input  logic            alu_zero,
  output logic            imem_req,
  output logic            dmem_req,
  output logic            dmem_we,
  output logic            ir_en,
  output logic            pc_en,
  output logic            pc_from_latch,
  output logic            ab_en,
  output logic            res_en,
  output logic            mdr_en,
  output logic            rf_we,
  output logic            rf_dst_rd,
  output logic            rf_from_mdr,
  output logic            opa_is_pc,
  output opb_sel_t        opb_sel,
  output alu_op_t         alu_op
);
  step_t  step_q, step_d;
  ikind_t kind;

  assign kind = classify(op, fn, shamt);

  always_comb begin
    step_d = step_q;
    imem_req = 1'b0; dmem_req = 1'b0; dmem_we = 1'b0;
    ir_en = 1'b0; pc_en = 1'b0; pc_from_latch = 1'b0;
    ab_en = 1'b0; res_en = 1'b0; mdr_en = 1'b0;
    rf_we = 1'b0; rf_dst_rd = 1'b0; rf_from_mdr = 1'b0;
    opa_is_pc = 1'b0; opb_sel = OPB_REG; alu_op = ALU_ADD;
    case (step_q)
      ST_FETCH: begin
        imem_req = 1'b1; opa_is_pc = 1'b1; opb_sel = OPB_FOUR;
        if (imem_ack) begin
          ir_en = 1'b1; pc_en = 1'b1; step_d = ST_DECODE;
        end
      end
      ST_DECODE: begin
        // Branch target formed before the opcode is known.
        ab_en = 1'b1; res_en = 1'b1; opa_is_pc = 1'b1; opb_sel = OPB_IMM;
        step_d = (kind == K_BAD) ? ST_FETCH : ST_EXEC;
      end
      ST_EXEC: begin
        step_d = ST_MEM;
        case (kind)
          K_LOAD, K_STORE: begin opb_sel = OPB_IMM; res_en = 1'b1; end
          K_ARITH:         begin alu_op = fn_to_op(fn); res_en = 1'b1; end
          K_BRANCH: begin
            alu_op = ALU_SUB; step_d = ST_FETCH;
            if (alu_zero) begin pc_en = 1'b1; pc_from_latch = 1'b1; end
          end
          default: step_d = ST_FETCH;
        endcase
      end
      ST_MEM: begin
        if (kind == K_ARITH) begin
          rf_we = 1'b1; rf_dst_rd = 1'b1; step_d = ST_FETCH;
        end else begin
          dmem_req = 1'b1; dmem_we = (kind == K_STORE);
          if (dmem_ack) begin
            mdr_en = (kind == K_LOAD);
            step_d = (kind == K_LOAD) ? ST_WB : ST_FETCH;
          end
        end
      end
      ST_WB: begin
        rf_we = 1'b1; rf_from_mdr = 1'b1; step_d = ST_FETCH;
      end
      default: step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req && dmem_req));
  p_dreq_in_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req |-> (step_q == ST_MEM) && (kind == K_LOAD || kind == K_STORE));
  p_branch_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_EXEC && kind == K_BRANCH) |=> step_q == ST_FETCH);
  p_bad_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_DECODE && kind == K_BAD) |=> step_q == ST_FETCH && !rf_we && !dmem_req);
  p_fetch_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_FETCH && !imem_ack) |=> step_q == ST_FETCH);
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req,
  output logic [XLEN-1:0] imem_addr,
  input  logic            imem_ack,
  input  logic [XLEN-1:0] imem_rdata,
  output logic            dmem_req,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic            dmem_ack,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
  logic [XLEN-1:0] rf_a, rf_b, imm_x, opa, opb, alu_y, wb_data;
  logic [RIDX_W-1:0] wb_addr;
  logic ir_en, pc_en, pc_from_latch, ab_en, res_en, mdr_en;
  logic rf_we, rf_dst_rd, rf_from_mdr, opa_is_pc, alu_zero;
  opb_sel_t opb_sel;
  alu_op_t  alu_op;

  assign imm_x = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync),
    .op(ir_q[31:26]), .fn(ir_q[5:0]), .shamt(ir_q[10:6]),
    .imem_ack(imem_ack), .dmem_ack(dmem_ack), .alu_zero(alu_zero),
    .imem_req(imem_req), .dmem_req(dmem_req), .dmem_we(dmem_we),
    .ir_en(ir_en), .pc_en(pc_en), .pc_from_latch(pc_from_latch),
    .ab_en(ab_en), .res_en(res_en), .mdr_en(mdr_en),
    .rf_we(rf_we), .rf_dst_rd(rf_dst_rd), .rf_from_mdr(rf_from_mdr),
    .opa_is_pc(opa_is_pc), .opb_sel(opb_sel), .alu_op(alu_op)
  );

  always_comb begin
    opa = opa_is_pc ? pc_q : a_q;
    case (opb_sel)
      OPB_FOUR: opb = XLEN'(4);
      OPB_IMM:  opb = imm_x;
      default:  opb = b_q;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .opa(opa), .opb(opb), .op(alu_op), .y(alu_y), .is_zero(alu_zero)
  );

  assign wb_addr = rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign wb_data = rf_from_mdr ? mdr_q : res_q;

  mc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk),
    .ra_addr(ir_q[25:21]), .ra_data(rf_a),
    .rb_addr(ir_q[20:16]), .rb_data(rf_b),
    .wr_en(rf_we), .wr_addr(wb_addr), .wr_data(wb_data)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      pc_q <= RESET_PC; ir_q <= '0; a_q <= '0; b_q <= '0; res_q <= '0; mdr_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_from_latch ? res_q : alu_y;
      if (ir_en)  ir_q  <= imem_rdata;
      if (ab_en)  begin a_q <= rf_a; b_q <= rf_b; end
      if (res_en) res_q <= alu_y;
      if (mdr_en) mdr_q <= dmem_rdata;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = res_q;
  assign dmem_wdata = b_q;

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    (imem_req && imem_ack) |=> pc_q == $past(pc_q) + XLEN'(4));
  p_imem_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (imem_req && !imem_ack) |=> imem_req && $stable(imem_addr));
  p_dmem_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (dmem_req && !dmem_ack) |=> dmem_req && $stable(dmem_addr) &&
                               $stable(dmem_wdata) && $stable(dmem_we));
  p_no_dreq_in_reset_r1: assert property (@(posedge clk) !rst_sync |-> !dmem_req);
endmodule

// File: tb/tb_mc_core.sv
module tb_mc_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_VEC = 32'h40;
  localparam int BASE = 16;

  logic clk = 0, rst_n = 0;
  logic imem_req, imem_ack = 0, dmem_req, dmem_we, dmem_ack = 0;
  logic [31:0] imem_addr, imem_rdata = 0, dmem_addr, dmem_wdata, dmem_rdata = 0;

  mc_core #(.RESET_PC(RST_VEC)) dut (
    .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
    .imem_ack(imem_ack), .imem_rdata(imem_rdata), .dmem_req(dmem_req),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_ack(dmem_ack), .dmem_rdata(dmem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int wi = 0, wd = 0, icnt = 0, dcnt = 0;
  int n_tests = 0, n_fail = 0;
  int cyc = 0, live = 0, nlog = 0, halts = 0, overlap = 0, hold_bad = 0, dreq_in_rst = 0;
  logic [31:0] halt_addr;
  logic [31:0] log_addr [64];
  int          log_cyc  [64];
  logic        p_ireq = 0, p_iack = 0, p_dreq = 0, p_dack = 0;
  logic [31:0] p_iaddr = 0, p_daddr = 0;

  // Memory responder: drives acks away from the active edge.
  always @(negedge clk) begin
    if (!rst_n && dmem_req) dreq_in_rst++;
    if (p_ireq && !p_iack && imem_req && imem_addr !== p_iaddr) hold_bad++;
    if (p_dreq && !p_dack && dmem_req && dmem_addr !== p_daddr) hold_bad++;
    if (imem_req) begin
      if (icnt == wi) begin imem_ack <= 1; imem_rdata <= imem[imem_addr[7:2]]; icnt = 0; end
      else begin imem_ack <= 0; icnt++; end
    end else begin imem_ack <= 0; icnt = 0; end
    if (dmem_req) begin
      if (dcnt == wd) begin dmem_ack <= 1; dmem_rdata <= dmem[dmem_addr[7:2]]; dcnt = 0; end
      else begin dmem_ack <= 0; dcnt++; end
    end else begin dmem_ack <= 0; dcnt = 0; end
  end

  always @(posedge clk) begin
    cyc++;
    p_ireq = imem_req; p_iack = imem_ack; p_iaddr = imem_addr;
    p_dreq = dmem_req; p_dack = dmem_ack; p_daddr = dmem_addr;
    if (rst_n) begin
      if (live >= 2) begin
        if (imem_req && dmem_req) overlap++;
        if (imem_req && imem_ack) begin
          if (nlog < 64) begin log_addr[nlog] = imem_addr; log_cyc[nlog] = cyc; nlog++; end
          if (imem_addr == halt_addr) halts++;
        end
        if (dmem_req && dmem_we && dmem_ack) dmem[dmem_addr[7:2]] = dmem_wdata;
      end
      live++;
    end else live = 0;
  end

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] halt_word();
    return enc_i(6'h04, 0, 0, 16'hFFFC);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin imem[i] = 32'hFC00_0000; dmem[i] = 32'hAAAA_AAAA; end
  endtask

  task automatic run_prog(int wi_v, int wd_v, int last);
    wi = wi_v; wd = wd_v; nlog = 0; halts = 0; overlap = 0; hold_bad = 0; dreq_in_rst = 0;
    halt_addr = RST_VEC + 32'(4*last);
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int t = 0; t < 5000 && halts < 2; t++) @(negedge clk);
    if (halts < 2) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d halts expected 2", halts);
    end
  endtask

  task automatic load_arith_prog();
    clear_mem();
    dmem[0] = 7; dmem[1] = 32'hFFFF_FFFD; dmem[2] = 32'h0F0F; dmem[3] = 32'h00FF;
    imem[BASE+0]  = enc_i(6'h23, 1, 0, 16'd0);
    imem[BASE+1]  = enc_i(6'h23, 2, 0, 16'd4);
    imem[BASE+2]  = enc_i(6'h23, 3, 0, 16'd8);
    imem[BASE+3]  = enc_i(6'h23, 4, 0, 16'd12);
    imem[BASE+4]  = enc_r(6'h20, 5, 1, 2);
    imem[BASE+5]  = enc_r(6'h22, 6, 1, 2);
    imem[BASE+6]  = enc_r(6'h24, 7, 3, 4);
    imem[BASE+7]  = enc_r(6'h25, 8, 3, 4);
    imem[BASE+8]  = enc_r(6'h2a, 9, 2, 1);
    imem[BASE+9]  = enc_r(6'h2a, 10, 1, 2);
    for (int k = 0; k < 6; k++) imem[BASE+10+k] = enc_i(6'h2b, 5+k, 0, 16'(64+4*k));
    imem[BASE+16] = halt_word();
  endtask

  task automatic test_arith();
    load_arith_prog();
    run_prog(0, 0, 16);
    chk("R1 no data request in reset", 32'(dreq_in_rst), 0);
    chk("R1 first fetch at vector", log_addr[0], RST_VEC);
    for (int k = 1; k <= 16; k++)
      if (log_addr[k] !== RST_VEC + 32'(4*k)) chk("R2 sequential fetch", log_addr[k], RST_VEC + 32'(4*k));
    chk("R2 fetch count", 32'(nlog >= 17), 1);
    chk("R3 add", dmem[16], 32'd4);
    chk("R3 sub", dmem[17], 32'd10);
    chk("R3 and", dmem[18], 32'h0F);
    chk("R3 or",  dmem[19], 32'h0FFF);
    chk("R3 slt true signed", dmem[20], 32'd1);
    chk("R3 slt false", dmem[21], 32'd0);
    chk("R4 load cycles", 32'(log_cyc[1]-log_cyc[0]), 5);
    chk("R3 arith cycles", 32'(log_cyc[5]-log_cyc[4]), 4);
    chk("R5 store cycles", 32'(log_cyc[11]-log_cyc[10]), 4);
    chk("R10 no port overlap", 32'(overlap), 0);
  endtask

  task automatic test_mem_branch_bad();
    clear_mem();
    dmem[0] = 7; dmem[1] = 32'hFFFF_FFFD; dmem[4] = 32; dmem[7] = 0;
    imem[BASE+0]  = enc_i(6'h23, 1, 0, 16'd0);
    imem[BASE+1]  = enc_i(6'h23, 2, 0, 16'd4);
    imem[BASE+2]  = enc_i(6'h23, 12, 0, 16'd16);
    imem[BASE+3]  = enc_i(6'h2b, 2, 12, 16'hFFFC);
    imem[BASE+4]  = enc_i(6'h23, 13, 12, 16'hFFFC);
    imem[BASE+5]  = enc_r(6'h20, 13, 13, 13);
    imem[BASE+6]  = enc_i(6'h2b, 13, 0, 16'd80);
    imem[BASE+7]  = enc_r(6'h20, 0, 1, 1);
    imem[BASE+8]  = enc_i(6'h23, 0, 0, 16'd0);
    imem[BASE+9]  = enc_i(6'h2b, 0, 0, 16'd84);
    imem[BASE+10] = enc_i(6'h04, 2, 1, 16'd4);
    imem[BASE+11] = enc_i(6'h2b, 1, 0, 16'd88);
    imem[BASE+12] = enc_i(6'h04, 1, 1, 16'd4);
    imem[BASE+13] = enc_i(6'h2b, 2, 0, 16'd92);
    imem[BASE+14] = enc_i(6'h2b, 1, 0, 16'd96);
    imem[BASE+15] = 32'hFC00_0000;
    imem[BASE+16] = {6'h00, 5'd2, 5'd2, 5'd1, 5'd0, 6'h01};
    imem[BASE+17] = enc_i(6'h2b, 1, 0, 16'd100);
    imem[BASE+18] = halt_word();
    run_prog(0, 0, 18);
    chk("R5 store negative offset", dmem[7], 32'hFFFF_FFFD);
    chk("R4 load negative offset", dmem[20], 32'hFFFF_FFFA);
    chk("R7 r0 stays zero", dmem[21], 32'd0);
    chk("R6 not taken falls through", dmem[22], 32'd7);
    chk("R6 taken skips", dmem[23], 32'hAAAA_AAAA);
    chk("R6 taken target", log_addr[13], RST_VEC + 32'(4*14));
    chk("R6 not taken cycles", 32'(log_cyc[11]-log_cyc[10]), 3);
    chk("R6 taken cycles", 32'(log_cyc[13]-log_cyc[12]), 3);
    chk("R8 bad opcode cycles", 32'(log_cyc[15]-log_cyc[14]), 2);
    chk("R8 bad funct cycles", 32'(log_cyc[16]-log_cyc[15]), 2);
    chk("R8 no register change", dmem[25], 32'd7);
  endtask

  task automatic test_wait_states();
    load_arith_prog();
    run_prog(2, 3, 16);
    chk("R9 add under waits", dmem[16], 32'd4);
    chk("R9 or under waits", dmem[19], 32'h0FFF);
    chk("R9 request held stable", 32'(hold_bad), 0);
    chk("R9 load cycles with waits", 32'(log_cyc[1]-log_cyc[0]), 5 + 3 + 2);
    chk("R10 no port overlap under waits", 32'(overlap), 0);
  endtask

  initial begin
    halt_addr = 32'hFFFF_FFFF;
    test_arith();
    test_mem_branch_bad();
    test_wait_states();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule